// File: doc/BRIEF.md
# BCD Clock-Calendar Register Counter

This block keeps wall-clock time as a set of BCD registers: seconds, minutes, hours in 24-hour form, day of week, day of month, month, two-digit year and a century flag. It advances by one second for each pulse on a one-second enable input. The pulse comes from a divider outside the block. A host reads and writes the time through a byte-wide port that is addressed over eight locations. Seven of them hold time fields and the eighth is a plain control byte.

While the host holds a read of any time location, the block changes no time register. Seconds that arrive during that window are not dropped. They are counted in a small pending counter and applied one per clock cycle once the read is released. A read window that lasts too long raises a flag. A stop bit freezes timekeeping. A century-enable bit decides whether the century flag inverts when the year wraps.

The hold logic is a three-state machine with these states:
- `HS_RUN`: ticks are applied directly.
- `HS_HOLD`: a time read is in progress, and ticks are counted.
- `HS_DRAIN`: pending ticks are being applied.

Its transitions are:
- `RUN->HOLD` when a hold begins.
- `HOLD->DRAIN` when the hold ends with ticks pending.
- `HOLD->RUN` when the hold ends with none pending.
- `DRAIN->HOLD` when a new hold begins.
- `DRAIN->RUN` when the pending count reaches zero.

Top module: `rtc_bcd_core`

## Requirements
- R1: On each accepted tick, seconds count in BCD and wrap from 59 to 00. That wrap advances minutes, which wrap from 59 to 00. That wrap advances hours, which wrap from 23 to 00. A ones digit of 9 or more resets to 0 and increments the tens digit.
- R2: When hours wrap, day of week advances and wraps from 7 to 1. At the same time the date advances and wraps to 01 after the last day of the month: 30 days for months 04, 06, 09 and 11, and 31 days for the other months except February. A date wrap advances the month, which wraps from 12 to 01.
- R3: February ends after 29 when the year value is divisible by four, and after 28 otherwise.
- R4: A year wrap from 99 to 00 inverts the century bit (address 2 bit 6) when the century-enable bit (address 2 bit 7) is 1. When the enable is 0, the century bit never changes.
- R5: Bit 7 of address 0 is the stop bit. While it is 1, ticks are discarded and the time does not change. Writing 0 resumes counting.
- R6: Register layout is as follows:
  - address 0: stop in bit 7, seconds in bits 6:0.
  - address 1: minutes in bits 6:0.
  - address 2: enable, century and hours in bits 5:0.
  - address 3: day of week in bits 2:0.
  - address 4: date in bits 5:0.
  - address 5: month in bits 4:0.
  - address 6: year in bits 7:0.
  - address 7: eight control bits, stored as written.

  Unused bits read 0. After reset the addresses 0 to 7 read 00, 00, 00, 01, 01, 01, 00, 80.
- R7: A host write to addresses 0-6 takes priority over a tick in the same cycle, and that tick is discarded. A write to address 7 does not block a tick.
- R8: A field whose value is at or above its wrap limit goes to its wrap value on its next advance and carries, even if the host wrote invalid BCD. Invalid values are stored as written.
- R9: While `host_rd_hold` is 1 and `host_addr` is 0-6, no time register changes unless the host writes it. A hold request at address 7 holds nothing.
- R10: Ticks accepted during a hold are counted up to a saturation limit of 2^PEND_W-1. After release, they are applied one per cycle. The first one is applied on the second clock edge after release.
- R11: `hold_timeout` rises once a hold has been seen on HOLD_LIMIT clock edges. It falls on the first edge after the hold ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rd_hold | input | 1 | Host read of `host_addr` in progress |
| host_rdata | output | 8 | Register contents at `host_addr` |
| hold_timeout | output | 1 | Read hold has lasted too long |

## Verification
The bench builds the block with PEND_W = 3 and HOLD_LIMIT = 6. With these values the pending counter saturates at seven, so a ten-tick hold shows saturation within a few cycles. The timeout threshold is also reachable in six cycles instead of a quarter second. Under these settings the bench can see the edge where a drain starts, the exact saturation point and both edges of the timeout flag. Calendar rollovers are reached by writing the fields close to their limits and then giving single ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        HS_RUN   = 2'd0,
        HS_HOLD  = 2'd1,
        HS_DRAIN = 2'd2
    } hold_state_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hr;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] yr;
        logic       ceb;
        logic       cb;
    } tm_t;

    localparam logic [2:0] ADDR_SEC  = 3'd0;
    localparam logic [2:0] ADDR_MIN  = 3'd1;
    localparam logic [2:0] ADDR_HR   = 3'd2;
    localparam logic [2:0] ADDR_DOW  = 3'd3;
    localparam logic [2:0] ADDR_DATE = 3'd4;
    localparam logic [2:0] ADDR_MON  = 3'd5;
    localparam logic [2:0] ADDR_YR   = 3'd6;
    localparam logic [2:0] ADDR_CTL  = 3'd7;

    localparam logic [7:0] CTL_RESET = 8'h80;

    localparam tm_t TM_RESET = '{sec: 7'h00, min: 7'h00, hr: 6'h00,
                                 dow: 3'h1, date: 6'h01, mon: 5'h01,
                                 yr: 8'h00, ceb: 1'b0, cb: 1'b0};

    // Last BCD date of a month; leap rule applied to the two-digit year
    function automatic logic [7:0] month_last_day(input logic [4:0] mon,
                                                  input logic [7:0] yr);
        logic [7:0] ybin;
        ybin = 8'(yr[7:4]) * 8'd10 + 8'(yr[3:0]);
        case (mon)
            5'h02:                      return ((ybin & 8'd3) == 8'd0) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
// One BCD field: advances when en, wraps to base at or above limit
module rtc_bcd_field #(
    parameter int W = 7
) (
    input  logic [W-1:0] val,
    input  logic [7:0]   limit,
    input  logic [7:0]   base,
    input  logic         en,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    logic [7:0] v8;
    logic [7:0] r8;

    always_comb begin
        v8   = 8'(val);
        wrap = en && (v8 >= limit);
        if (!en)
            r8 = v8;
        else if (v8 >= limit)
            r8 = base;
        else if (v8[3:0] >= 4'd9)
            r8 = {v8[7:4] + 4'd1, 4'h0};
        else
            r8 = v8 + 8'd1;
        nxt = r8[W-1:0];
    end
endmodule

// File: rtl/rtc_cal_next.sv
// Combinational one-second advance of the whole calendar
module rtc_cal_next
    import rtc_pkg::*;
(
    input  tm_t cur,
    output tm_t nxt
);
    logic w_sec, w_min, w_hr, w_date, w_mon, w_yr;
    logic dow_wrap_unused;
    logic [7:0] last_day;

    assign last_day = month_last_day(cur.mon, cur.yr);

    rtc_bcd_field #(.W(7)) u_sec (.val(cur.sec), .limit(8'h59), .base(8'h00),
        .en(1'b1), .nxt(nxt.sec), .wrap(w_sec));
    rtc_bcd_field #(.W(7)) u_min (.val(cur.min), .limit(8'h59), .base(8'h00),
        .en(w_sec), .nxt(nxt.min), .wrap(w_min));
    rtc_bcd_field #(.W(6)) u_hr (.val(cur.hr), .limit(8'h23), .base(8'h00),
        .en(w_min), .nxt(nxt.hr), .wrap(w_hr));
    rtc_bcd_field #(.W(3)) u_dow (.val(cur.dow), .limit(8'h07), .base(8'h01),
        .en(w_hr), .nxt(nxt.dow), .wrap(dow_wrap_unused));
    rtc_bcd_field #(.W(6)) u_date (.val(cur.date), .limit(last_day), .base(8'h01),
        .en(w_hr), .nxt(nxt.date), .wrap(w_date));
    rtc_bcd_field #(.W(5)) u_mon (.val(cur.mon), .limit(8'h12), .base(8'h01),
        .en(w_date), .nxt(nxt.mon), .wrap(w_mon));
    rtc_bcd_field #(.W(8)) u_yr (.val(cur.yr), .limit(8'h99), .base(8'h00),
        .en(w_mon), .nxt(nxt.yr), .wrap(w_yr));

    assign nxt.ceb = cur.ceb;
    assign nxt.cb  = cur.cb ^ (w_yr & cur.ceb);
endmodule

// File: rtl/rtc_hold_ctrl.sv
// Read-hold state machine with pending-tick counter and hold timer
module rtc_hold_ctrl
    import rtc_pkg::*;
#(
    parameter int PEND_W     = 3,
    parameter int HOLD_LIMIT = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold_req,
    input  logic stopped,
    input  logic wr_time,
    output logic step,
    output logic hold_timeout
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
    localparam int                HCNT_W   = $clog2(HOLD_LIMIT + 1);

    hold_state_e       state_q, state_d;
    logic [PEND_W-1:0] pend_q, pend_d;
    logic [HCNT_W-1:0] hcnt_q;
    logic              take;
    logic              pend_nz;

    assign pend_nz = (pend_q != '0);
    assign take    = tick && !stopped && !wr_time;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_RUN:   if (hold_req) state_d = HS_HOLD;
            HS_HOLD:  if (!hold_req) state_d = pend_nz ? HS_DRAIN : HS_RUN;
            HS_DRAIN: if (hold_req) state_d = HS_HOLD;
                      else if (pend_d == '0) state_d = HS_RUN;
            default:  state_d = HS_RUN;
        endcase
    end

    // outputs
    always_comb begin
        step = 1'b0;
        unique case (state_q)
            HS_RUN, HS_DRAIN: step = !hold_req && !stopped && !wr_time && (tick || pend_nz);
            HS_HOLD:          step = 1'b0;
            default:          step = 1'b0;
        endcase
    end

    always_comb begin
        pend_d = pend_q;
        if (take && !step && pend_q != PEND_MAX) pend_d = pend_q + 1'b1;
        else if (!take && step)                  pend_d = pend_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q       <= '0;
            hcnt_q       <= '0;
            hold_timeout <= 1'b0;
        end else begin
            pend_q <= pend_d;
            if (!hold_req)                      hcnt_q <= '0;
            else if (hcnt_q < HCNT_W'(HOLD_LIMIT)) hcnt_q <= hcnt_q + 1'b1;
            hold_timeout <= hold_req && (hcnt_q >= HCNT_W'(HOLD_LIMIT - 1));
        end
    end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int PEND_W     = 3,
    parameter int HOLD_LIMIT = 62_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       host_we,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_rd_hold,
    output logic [7:0] host_rdata,
    output logic       hold_timeout
);
    tm_t        tm_q;
    tm_t        tm_nxt;
    logic       stop_q;
    logic [7:0] ctl_q;
    logic       hold_req;
    logic       wr_time;
    logic       step;

    assign hold_req = host_rd_hold && (host_addr != ADDR_CTL);
    assign wr_time  = host_we && (host_addr != ADDR_CTL);

    rtc_cal_next u_next (.cur(tm_q), .nxt(tm_nxt));

    rtc_hold_ctrl #(.PEND_W(PEND_W), .HOLD_LIMIT(HOLD_LIMIT)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .hold_req(hold_req),
        .stopped(stop_q), .wr_time(wr_time), .step(step),
        .hold_timeout(hold_timeout)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q   <= TM_RESET;
            stop_q <= 1'b0;
            ctl_q  <= CTL_RESET;
        end else begin
            if (step) tm_q <= tm_nxt;
            if (host_we) begin
                case (host_addr)
                    ADDR_SEC:  {stop_q, tm_q.sec} <= host_wdata;
                    ADDR_MIN:  tm_q.min <= host_wdata[6:0];
                    ADDR_HR:   {tm_q.ceb, tm_q.cb, tm_q.hr} <= host_wdata;
                    ADDR_DOW:  tm_q.dow <= host_wdata[2:0];
                    ADDR_DATE: tm_q.date <= host_wdata[5:0];
                    ADDR_MON:  tm_q.mon <= host_wdata[4:0];
                    ADDR_YR:   tm_q.yr <= host_wdata;
                    ADDR_CTL:  ctl_q <= host_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        case (host_addr)
            ADDR_SEC:  host_rdata = {stop_q, tm_q.sec};
            ADDR_MIN:  host_rdata = {1'b0, tm_q.min};
            ADDR_HR:   host_rdata = {tm_q.ceb, tm_q.cb, tm_q.hr};
            ADDR_DOW:  host_rdata = {5'b0, tm_q.dow};
            ADDR_DATE: host_rdata = {2'b0, tm_q.date};
            ADDR_MON:  host_rdata = {3'b0, tm_q.mon};
            ADDR_YR:   host_rdata = tm_q.yr;
            default:   host_rdata = ctl_q;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_we,
    input logic [2:0] host_addr,
    input logic [7:0] host_wdata,
    input logic       host_rd_hold,
    input logic       hold_timeout,
    input logic       stop_q,
    input logic [6:0] sec_q,
    input logic [6:0] min_q,
    input logic [5:0] hr_q,
    input logic [7:0] yr_q,
    input logic       ceb_q,
    input logic       cb_q
);
    assert_stop_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !host_we) |=> $stable(sec_q));

    assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_hold && host_addr != 3'd7 && !host_we)
        |=> $stable({sec_q, min_q, hr_q, yr_q, cb_q}));

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 3'd0) |=> (sec_q == $past(host_wdata[6:0])));

    assert_century_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ceb_q && !host_we) |=> $stable(cb_q));

    assert_timeout_needs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_timeout) |-> $past(host_rd_hold && host_addr != 3'd7));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rd_hold(host_rd_hold),
    .hold_timeout(hold_timeout), .stop_q(stop_q), .sec_q(tm_q.sec),
    .min_q(tm_q.min), .hr_q(tm_q.hr), .yr_q(tm_q.yr), .ceb_q(tm_q.ceb),
    .cb_q(tm_q.cb)
);

// File: tb/rtc_bcd_core_bench.sv
module rtc_bcd_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_rd_hold = 1'b0;
    logic [7:0] host_rdata;
    logic       hold_timeout;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtc_bcd_core #(.PEND_W(3), .HOLD_LIMIT(6)) u_rtc_bcd_core (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd_hold(host_rd_hold), .host_rdata(host_rdata),
        .hold_timeout(hold_timeout)
    );

    // {req[3:0], write bytes addr0..6, expected bytes addr0..6}
    localparam int NV = 14;
    localparam logic [115:0] VEC [NV] = '{
        {4'd1, 56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00}, // R1
        {4'd1, 56'h09_00_00_01_01_01_00, 56'h10_00_00_01_01_01_00}, // R1
        {4'd1, 56'h59_12_00_01_01_01_00, 56'h00_13_00_01_01_01_00}, // R1
        {4'd1, 56'h59_59_19_01_01_01_00, 56'h00_00_20_01_01_01_00}, // R1
        {4'd2, 56'h59_59_23_03_30_04_10, 56'h00_00_00_04_01_05_10}, // R2
        {4'd2, 56'h59_59_23_07_30_05_10, 56'h00_00_00_01_31_05_10}, // R2
        {4'd3, 56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24}, // R3
        {4'd3, 56'h59_59_23_03_28_02_23, 56'h00_00_00_04_01_03_23}, // R3
        {4'd3, 56'h59_59_23_02_29_02_24, 56'h00_00_00_03_01_03_24}, // R3
        {4'd4, 56'h59_59_E3_07_31_12_99, 56'h00_00_80_01_01_01_00}, // R4
        {4'd4, 56'h59_59_63_07_31_12_99, 56'h00_00_40_01_01_01_00}, // R4
        {4'd8, 56'h3C_10_05_02_10_06_50, 56'h40_10_05_02_10_06_50}, // R8
        {4'd8, 56'h59_7F_05_02_10_06_50, 56'h00_00_06_02_10_06_50}, // R8
        {4'd2, 56'h59_59_23_03_31_12_19, 56'h00_00_00_04_01_01_20}  // R2
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic tick1();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R6 reset a%0d", a), v, (a == 3 || a == 4 || a == 5) ? 8'h01 :
                                                 (a == 7) ? 8'h80 : 8'h00);
        end

        // vector table
        for (int i = 0; i < NV; i++) begin
            for (int a = 0; a < 7; a++) wr(3'(a), VEC[i][111 - 8*a -: 8]);
            tick1();
            for (int a = 0; a < 7; a++) begin
                rd(3'(a), v);
                chk($sformatf("R%0d v%0d a%0d", VEC[i][115:112], i, a), v, VEC[i][55 - 8*a -: 8]);
            end
        end

        // R6 unused bits read zero, control stored as written
        wr(3'd1, 8'hFF); rd(3'd1, v); chk("R6 min mask", v, 8'h7F);
        wr(3'd3, 8'hFF); rd(3'd3, v); chk("R6 dow mask", v, 8'h07);
        wr(3'd4, 8'hFF); rd(3'd4, v); chk("R6 date mask", v, 8'h3F);
        wr(3'd5, 8'hFF); rd(3'd5, v); chk("R6 mon mask", v, 8'h1F);
        wr(3'd7, 8'h5A); rd(3'd7, v); chk("R6 control", v, 8'h5A);
        wr(3'd1, 8'h00); wr(3'd4, 8'h01); wr(3'd5, 8'h01); wr(3'd3, 8'h01);

        // R5 stop bit
        wr(3'd0, 8'h90); tick1(); tick1();
        rd(3'd0, v); chk("R5 stopped", v, 8'h90);
        wr(3'd0, 8'h10); tick1();
        rd(3'd0, v); chk("R5 resumed", v, 8'h11);

        // R7 write beats tick; control write does not block tick
        @(negedge clk);
        host_we = 1'b1; host_addr = 3'd0; host_wdata = 8'h30; tick_1hz = 1'b1;
        @(negedge clk);
        host_we = 1'b0; tick_1hz = 1'b0;
        rd(3'd0, v); chk("R7 write wins", v, 8'h30);
        @(negedge clk);
        host_we = 1'b1; host_addr = 3'd7; host_wdata = 8'h21; tick_1hz = 1'b1;
        @(negedge clk);
        host_we = 1'b0; tick_1hz = 1'b0;
        rd(3'd0, v); chk("R7 ctl write keeps tick", v, 8'h31);

        // R9 hold and R10 drain timing
        wr(3'd0, 8'h00);
        host_addr = 3'd0; host_rd_hold = 1'b1;
        tick1(); tick1(); tick1();
        rd(3'd0, v); chk("R9 held", v, 8'h00);
        host_rd_hold = 1'b0;
        @(negedge clk); rd(3'd0, v); chk("R10 no step first edge", v, 8'h00);
        @(negedge clk); rd(3'd0, v); chk("R10 first step", v, 8'h01);
        repeat (4) @(negedge clk);
        rd(3'd0, v); chk("R10 all pending applied", v, 8'h03);

        // R9 address 7 holds nothing
        host_addr = 3'd7; host_rd_hold = 1'b1;
        tick1();
        host_rd_hold = 1'b0;
        rd(3'd0, v); chk("R9 ctl read no hold", v, 8'h04);

        // R10 saturation at seven
        host_addr = 3'd0; host_rd_hold = 1'b1;
        for (int k = 0; k < 10; k++) tick1();
        host_rd_hold = 1'b0;
        repeat (12) @(negedge clk);
        rd(3'd0, v); chk("R10 saturated", v, 8'h11);

        // R11 timeout flag
        @(negedge clk);
        host_addr = 3'd2; host_rd_hold = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 short hold", {7'b0, hold_timeout}, 8'h00);
        repeat (2) @(negedge clk);
        chk("R11 below limit", {7'b0, hold_timeout}, 8'h00);
        @(negedge clk);
        chk("R11 at limit", {7'b0, hold_timeout}, 8'h01);
        host_rd_hold = 1'b0;
        @(negedge clk);
        chk("R11 released", {7'b0, hold_timeout}, 8'h00);

        report();
    end
endmodule